// File: doc/BRIEF.md
# Converter Serial Result Port

This block takes the result word that a conversion engine delivers, along with that engine's busy flag and a one-cycle ready strobe, and sends the word out MSB first on a single serial data line. A framing signal marks the sixteen data-bit periods. The port has two clocking modes. In master mode it makes its own serial clock by dividing the system clock. In slave mode it follows a serial clock supplied from outside, which it synchronises into the system clock domain.

Configuration inputs choose the output coding (straight binary or two's complement), the polarity of the frame signal, and the polarity of the serial clock. In master mode a shared select input sets the read timing: the word can go out while the next conversion is still busy, or only once the engine is idle. In the second case a 2-bit code slows the serial clock. In slave mode the same shared input becomes a cascade input. Its bits follow the local word on the data line with no gap, so several converters can share one line.

Top module: `conv_serial_port`

## Requirements
- R1: While reset is held and after it is released with no word pending, `sync_o` equals `sync_inv_i`, `sdo_o` is 0, and in master mode `sclk_o` rests at the level of `sclk_inv_i`.
- R2: Each word goes out MSB first over 16 serial-clock periods. The frame signal is active during exactly those periods. In master mode no serial clock edges appear outside a frame.
- R3: When `straight_i` is 1 the word is sent unchanged. When it is 0, bit 15 is inverted before shifting, which gives two's complement.
- R4: In master mode with `casc_rdsel_i` low, one serial clock period lasts 2^(`div_code_i`+1) system clocks, with equal high and low halves. With `casc_rdsel_i` high the period is 2 system clocks for any code.
- R5: In master mode with `casc_rdsel_i` low, a frame never starts while `busy_i` is 1. With `casc_rdsel_i` high, a frame starts while `busy_i` is 1.
- R6: The frame signal is active high when `sync_inv_i` is 0 and active low when it is 1.
- R7: `sclk_inv_i` inverts the serial clock in both modes. The effective clock is the pin level XOR `sclk_inv_i`: in master mode this is the driven `sclk_o`, and in slave mode it is `sclk_ext_i`.
- R8: In slave mode (`clk_src_ext_i` = 1) a loaded word puts its MSB on `sdo_o` and raises the frame without any clock. Each falling edge of the effective external clock advances one bit. With no edges the output holds.
- R9: In slave mode `casc_rdsel_i` is sampled on each rising edge of the effective clock. After the 16 local bits, the sampled levels appear on `sdo_o` in order, one per period, with the first appearing 16 periods after the frame starts.
- R10: A ready strobe that arrives during a frame is held. Its word follows the current frame with no idle serial clock period between them.
- R11: In master mode `sdo_o` changes only while the effective serial clock is low, that is, on its falling edge or when a frame is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | 16 | Conversion result word |
| ready_i | input | 1 | One-cycle strobe: result_i is valid |
| busy_i | input | 1 | Conversion engine busy |
| straight_i | input | 1 | 1 = straight binary, 0 = two's complement |
| clk_src_ext_i | input | 1 | 0 = master (internal clock), 1 = slave (external clock) |
| div_code_i | input | 2 | Master clock slow-down code (read-after timing) |
| sync_inv_i | input | 1 | 1 = frame signal active low |
| sclk_inv_i | input | 1 | Inverts the serial clock |
| casc_rdsel_i | input | 1 | Master: 1 = read during busy; slave: cascade data in |
| sclk_ext_i | input | 1 | External serial clock (slave mode) |
| sclk_o | output | 1 | Serial clock driven in master mode (0 in slave mode) |
| sdo_o | output | 1 | Serial data out |
| sync_o | output | 1 | Frame signal |

## Verification
The hardest situation to reach is a frame boundary in which the next word is already pending when the sixteenth falling edge arrives. The load then replaces the shift on that same edge, and the bit period must stay unbroken. The stimulus gets there by sending a second ready strobe partway through a slowed master frame. A model of the bit periods then checks that the first bit of the second word rises exactly one period after the last bit of the first. The cascade path is reached with the bench acting as external clock master for thirty-two periods. It changes the cascade level before each rising edge and expects those levels back after the local word.

// File: rtl/csp_pkg.sv
package csp_pkg;
  // serial clock event seen in the system clock domain
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_CAP    = 2'd1,   // rising edge of the effective serial clock
    EV_LAUNCH = 2'd2    // falling edge of the effective serial clock
  } sclk_ev_e;
endpackage

// File: rtl/csp_word_hold.sv
module csp_word_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ready_i,
  input  logic         straight_i,
  input  logic [W-1:0] result_i,
  input  logic         take_i,
  output logic         pend_o,
  output logic [W-1:0] word_o
);
  logic [W-1:0] coded;

  // two's complement is straight binary with the top bit flipped
  always_comb begin
    coded      = result_i;
    coded[W-1] = result_i[W-1] ^ ~straight_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      word_o <= '0;
    end else if (ready_i) begin
      pend_o <= 1'b1;
      word_o <= coded;
    end else if (take_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/csp_clk_unit.sv
module csp_clk_unit
  import csp_pkg::*;
#(
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             rd_during_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             sclk_inv_i,
  input  logic             sclk_ext_i,
  output sclk_ev_e         ev_o,
  output logic             sclk_int_o
);
  localparam int CNT_W = 2 ** DIV_W;

  // ---------------- master: divided internal clock ----------------
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] hcnt;
  logic             toggle_now;

  always_comb begin
    half = rd_during_i ? CNT_W'(1) : (CNT_W'(1) << div_code_i);
  end

  assign toggle_now = run_i && (hcnt == half - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !master_i) begin
      sclk_int_o <= 1'b0;
      hcnt       <= '0;
    end else if (restart_i || !run_i) begin
      sclk_int_o <= 1'b0;
      hcnt       <= '0;
    end else if (toggle_now) begin
      sclk_int_o <= ~sclk_int_o;
      hcnt       <= '0;
    end else begin
      hcnt <= hcnt + CNT_W'(1);
    end
  end

  // ---------------- slave: synchronised external clock ----------------
  logic [SYNC_STAGES-1:0] sy;
  logic                   eff_q;
  logic                   eff;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sy <= sclk_inv_i;
        else     sy <= sclk_ext_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sy <= {SYNC_STAGES{sclk_inv_i}};
        else     sy <= {sy[SYNC_STAGES-2:0], sclk_ext_i};
      end
    end
  endgenerate

  assign eff = sy[SYNC_STAGES-1] ^ sclk_inv_i;

  always_ff @(posedge clk) begin
    if (rst) eff_q <= 1'b0;
    else     eff_q <= eff;
  end

  always_comb begin
    ev_o = EV_NONE;
    if (master_i) begin
      if (toggle_now) ev_o = sclk_int_o ? EV_LAUNCH : EV_CAP;
    end else begin
      if (eff && !eff_q)      ev_o = EV_CAP;
      else if (!eff && eff_q) ev_o = EV_LAUNCH;
    end
  end
endmodule

// File: rtl/csp_shifter.sv
module csp_shifter
  import csp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         master_i,
  input  sclk_ev_e     ev_i,
  input  logic         casc_i,
  input  logic         pend_i,
  input  logic [W-1:0] word_i,
  input  logic         allow_i,
  output logic         take_o,
  output logic         active_o,
  output logic         sdo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] left;
  logic          tail_q;
  logic          launch;
  logic          last;

  assign active_o = (left != '0);
  assign launch   = (ev_i == EV_LAUNCH);
  assign last     = active_o && launch && (left == CW'(1));
  assign take_o   = pend_i && allow_i && (!active_o || last);
  assign sdo_o    = sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= 1'b0;
    end else if (ev_i == EV_CAP) begin
      tail_q <= master_i ? 1'b0 : casc_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
    end else if (take_o) begin
      sr   <= word_i;
      left <= CW'(W);
    end else if (launch && (active_o || !master_i)) begin
      sr <= {sr[W-2:0], tail_q};
      if (active_o) left <= left - CW'(1);
    end
  end
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import csp_pkg::*;
#(
  parameter int W           = 16,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     result_i,
  input  logic             ready_i,
  input  logic             busy_i,
  input  logic             straight_i,
  input  logic             clk_src_ext_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic             sync_inv_i,
  input  logic             sclk_inv_i,
  input  logic             casc_rdsel_i,
  input  logic             sclk_ext_i,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             sync_o
);
  logic         master;
  logic         pend;
  logic [W-1:0] word;
  logic         take;
  logic         active;
  logic         allow;
  logic         sclk_int;
  sclk_ev_e     ev;

  assign master = !clk_src_ext_i;
  // master read-after timing waits for the engine to go idle
  assign allow  = !master || casc_rdsel_i || !busy_i;

  csp_word_hold #(.W(W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .ready_i    (ready_i),
    .straight_i (straight_i),
    .result_i   (result_i),
    .take_i     (take),
    .pend_o     (pend),
    .word_o     (word)
  );

  csp_clk_unit #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk         (clk),
    .rst         (rst),
    .master_i    (master),
    .run_i       (active),
    .restart_i   (take),
    .rd_during_i (casc_rdsel_i),
    .div_code_i  (div_code_i),
    .sclk_inv_i  (sclk_inv_i),
    .sclk_ext_i  (sclk_ext_i),
    .ev_o        (ev),
    .sclk_int_o  (sclk_int)
  );

  csp_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .master_i (master),
    .ev_i     (ev),
    .casc_i   (casc_rdsel_i),
    .pend_i   (pend),
    .word_i   (word),
    .allow_i  (allow),
    .take_o   (take),
    .active_o (active),
    .sdo_o    (sdo_o)
  );

  assign sclk_o = master ? (sclk_int ^ sclk_inv_i) : 1'b0;
  assign sync_o = active ^ sync_inv_i;
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busy_i,
  input logic             clk_src_ext_i,
  input logic [DIV_W-1:0] div_code_i,
  input logic             sync_inv_i,
  input logic             sclk_inv_i,
  input logic             casc_rdsel_i,
  input logic             sclk_o,
  input logic             sdo_o,
  input logic             sync_o
);
  localparam int LW = 2 ** DIV_W + 2;

  logic          sclk_e;
  logic          sync_a;
  logic          prev_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] half;

  assign sclk_e = sclk_o ^ sclk_inv_i;
  assign sync_a = sync_o ^ sync_inv_i;
  assign half   = casc_rdsel_i ? LW'(1) : (LW'(1) << div_code_i);

  // length of the current level of the effective master clock
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= sclk_e;
      len_q  <= '0;
    end else begin
      prev_q <= sclk_e;
      len_q  <= (sclk_e != prev_q) ? LW'(1) : len_q + LW'(1);
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (sync_o == sync_inv_i) && !sdo_o);  // R1

  AST_NO_CLK_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (!clk_src_ext_i && !sync_a) |-> !sclk_e);  // R2

  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
    (!clk_src_ext_i && !sclk_e && prev_q) |-> (len_q == half));  // R4

  AST_WAIT_FOR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clk_src_ext_i && !casc_rdsel_i && $rose(sync_a)) |-> !$past(busy_i));  // R5

  AST_SDO_ON_LOW_CLK: assert property (@(posedge clk) disable iff (rst)
    (!clk_src_ext_i && !$stable(sdo_o)) |-> !sclk_e);  // R11
endmodule

bind conv_serial_port csp_checker #(.DIV_W(DIV_W)) u_csp_checker (
  .clk           (clk),
  .rst           (rst),
  .busy_i        (busy_i),
  .clk_src_ext_i (clk_src_ext_i),
  .div_code_i    (div_code_i),
  .sync_inv_i    (sync_inv_i),
  .sclk_inv_i    (sclk_inv_i),
  .casc_rdsel_i  (casc_rdsel_i),
  .sclk_o        (sclk_o),
  .sdo_o         (sdo_o),
  .sync_o        (sync_o)
);

// File: tb/test_conv_serial_port.sv
module test_conv_serial_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] result_i = '0;
  logic        ready_i = 1'b0;
  logic        busy_i = 1'b0;
  logic        straight_i = 1'b1;
  logic        clk_src_ext_i = 1'b0;
  logic [1:0]  div_code_i = '0;
  logic        sync_inv_i = 1'b0;
  logic        sclk_inv_i = 1'b0;
  logic        casc_rdsel_i = 1'b1;
  logic        sclk_ext_i = 1'b0;
  logic        sclk_o, sdo_o, sync_o;

  always #5 clk = ~clk;

  conv_serial_port i_conv_serial_port (
    .clk(clk), .rst(rst), .result_i(result_i), .ready_i(ready_i), .busy_i(busy_i),
    .straight_i(straight_i), .clk_src_ext_i(clk_src_ext_i), .div_code_i(div_code_i),
    .sync_inv_i(sync_inv_i), .sclk_inv_i(sclk_inv_i), .casc_rdsel_i(casc_rdsel_i),
    .sclk_ext_i(sclk_ext_i), .sclk_o(sclk_o), .sdo_o(sdo_o), .sync_o(sync_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected bit periods of the master serial stream
  typedef struct packed { logic b; logic first; logic contig; } exp_t;
  exp_t q[$];
  bit   mon_on = 0;
  int   half_exp = 1;
  logic prev_e = 1'b0;
  logic e_now;
  int   last_rise = 0;
  exp_t x;

  task automatic push_word(input logic [15:0] w, input logic sb, input bit contig);
    logic [15:0] c;
    c = w;
    c[15] = w[15] ^ ~sb;
    for (int i = 15; i >= 0; i--) begin
      exp_t it;
      it.b = c[i]; it.first = (i == 15); it.contig = contig && (i == 15);
      q.push_back(it);
    end
  endtask

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (mon_on) begin
      e_now = sclk_o ^ sclk_inv_i;
      if (e_now && !prev_e) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 clock edge outside frame", 1, 0);
        end else begin
          x = q.pop_front();
          chk(sdo_o == x.b, "R2/R3 data bit", sdo_o, x.b);
          chk(sync_o == ~sync_inv_i, "R6 frame active level", sync_o, ~sync_inv_i);
          if (x.contig)
            chk(cyc - last_rise == 2*half_exp, "R10 gapless next frame", cyc - last_rise, 2*half_exp);
          else if (!x.first)
            chk(cyc - last_rise == 2*half_exp, "R4 serial period", cyc - last_rise, 2*half_exp);
        end
        last_rise = cyc;
      end
      prev_e = e_now;
    end else begin
      prev_e = sclk_o ^ sclk_inv_i;
    end
  end

  task automatic do_reset(input logic ext, input logic sinv, input logic cinv,
                          input logic rdsel, input logic [1:0] dv, input logic sb);
    @(negedge clk);
    mon_on = 0;
    rst = 1'b1;
    clk_src_ext_i = ext; sync_inv_i = sinv; sclk_inv_i = cinv;
    casc_rdsel_i = rdsel; div_code_i = dv; straight_i = sb;
    sclk_ext_i = cinv; busy_i = 1'b0; ready_i = 1'b0;
    half_exp = rdsel ? 1 : (1 << dv);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    prev_e = sclk_o ^ sclk_inv_i;
    mon_on = !ext;
  endtask

  task automatic strobe(input logic [15:0] w);
    @(negedge clk);
    result_i = w; ready_i = 1'b1;
    @(negedge clk);
    ready_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (2*half_exp + 4) @(negedge clk);
    chk(q.size() == 0, {tag, " all bits sent"}, q.size(), 0);
    chk(sync_o == sync_inv_i, {tag, " frame ended (R2)"}, sync_o, sync_inv_i);
    chk(sclk_o == sclk_inv_i, {tag, " clock idle (R2)"}, sclk_o, sclk_inv_i);
  endtask

  task automatic slave_run(input logic [15:0] w, input logic [31:0] casc);
    logic [15:0] c;
    logic e;
    c = w;  // straight binary in this run
    strobe(w);
    repeat (3) @(negedge clk);
    chk(sync_o == ~sync_inv_i, "R8 frame raised without clock", sync_o, ~sync_inv_i);
    chk(sdo_o == c[15], "R8 MSB before first edge", sdo_o, c[15]);
    repeat (30) @(negedge clk);
    chk(sdo_o == c[15], "R8 output holds with no edges", sdo_o, c[15]);
    for (int i = 0; i < 32; i++) begin
      e = (i < 16) ? c[15-i] : casc[31-(i-16)];
      chk(sdo_o == e, (i < 16) ? "R8/R7 slave data bit" : "R9 cascade bit", sdo_o, e);
      chk(sync_o == ((i < 16) ^ sync_inv_i), "R2 slave frame width", sync_o, (i < 16) ^ sync_inv_i);
      casc_rdsel_i = casc[31-i];
      sclk_ext_i = 1'b1 ^ sclk_inv_i;
      repeat (8) @(negedge clk);
      sclk_ext_i = 1'b0 ^ sclk_inv_i;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, master, inverted clock
    rst = 1'b1; sclk_inv_i = 1'b1; sclk_ext_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(sync_o == 1'b0 && sdo_o == 1'b0, "R1 outputs in reset", {sync_o, sdo_o}, 0);
    chk(sclk_o == 1'b1, "R1 clock rest level", sclk_o, 1);
    do_reset(0, 0, 1, 1, 2'd3, 1);
    repeat (5) @(negedge clk);
    chk(sync_o == 1'b0 && sdo_o == 1'b0 && sclk_o == 1'b1, "R1 idle after reset",
        {sync_o, sdo_o, sclk_o}, 1);

    // R5/R4: read during busy, divide code ignored, straight binary
    do_reset(0, 0, 0, 1, 2'd3, 1);
    busy_i = 1'b1;
    push_word(16'hA5C3, 1'b1, 0);
    strobe(16'hA5C3);
    repeat (3) @(negedge clk);
    chk(sync_o == 1'b1, "R5 frame starts while busy", sync_o, 1);
    drain("R4 read-during");
    busy_i = 1'b0;

    // R5/R4/R3: read after conversion, every divide code, two's complement
    for (int d = 0; d < 4; d++) begin
      do_reset(0, 0, 0, 0, d[1:0], 0);
      busy_i = 1'b1;
      push_word(16'h3C5A ^ 16'(d * 16'h1111), 1'b0, 0);
      strobe(16'h3C5A ^ 16'(d * 16'h1111));
      repeat (40) @(negedge clk);
      chk(sync_o == 1'b0 && sclk_o == 1'b0, "R5 no frame while busy", {sync_o, sclk_o}, 0);
      busy_i = 1'b0;
      drain("R3/R4 read-after");
    end

    // R10: strobe during a frame is held and follows without a gap
    do_reset(0, 0, 0, 0, 2'd1, 1);
    push_word(16'h8001, 1'b1, 0);
    strobe(16'h8001);
    repeat (20) @(negedge clk);
    push_word(16'h7FFE, 1'b1, 1);
    strobe(16'h7FFE);
    drain("R10 back-to-back");

    // R6/R7: both polarities inverted in master mode
    do_reset(0, 1, 1, 1, 2'd0, 0);
    chk(sync_o == 1'b1, "R6 inactive frame is high", sync_o, 1);
    push_word(16'h0F0F, 1'b0, 0);
    strobe(16'h0F0F);
    drain("R6/R7 inverted");

    // R8/R9: slave mode with cascade, both clock polarities
    do_reset(1, 0, 0, 0, 2'd0, 1);
    chk(sclk_o == 1'b0, "R7 slave drives no clock", sclk_o, 0);
    slave_run(16'hC3A6, 32'hD5B1_0E72);
    do_reset(1, 1, 1, 0, 2'd0, 1);
    slave_run(16'h5A3C, 32'h1248_F0E1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule